// File: doc/BRIEF.md
# Two-Stage Channel Attenuation Register Bank

This block is the attenuation register file of a multichannel audio DAC. Register writes arrive as a single-cycle strobe. Each strobe carries a 5-bit address and a 9-bit data word. A write never changes a channel's output level directly. Instead it fills that channel's pending latch. The active settings that drive the gain stages are reloaded from the pending latches only when a write carries the commit bit. That reload covers every channel at once, so a set of level changes on many channels takes effect on one clock edge.

There are two families of channel. Analogue channels hold a 7-bit code in 1 dB steps and a zero-cross enable. Digital channels hold an 8-bit code in 0.5 dB steps. A master address writes one analogue code and one zero-cross enable into the pending latch of every analogue channel.

The address map is set by parameters. Analogue channel k sits at `ANA_BASE + k`, the master register sits at `MASTER_ADDR`, and digital channel k sits at `DIG_BASE + k`. With the defaults the map is as follows:
- Analogue channels 0 to 7 sit at addresses 0 to 7, so left and right of pair 4 are at 6 and 7.
- The master register sits at address 8.
- Digital channels 0 to 7 sit at addresses 9 to 16.

Top module: `att_bank`

## Requirements
- R1: During reset, and after it, every analogue code reads 7'h7F (0 dB), every zero-cross enable reads 0, and every digital code reads 8'hFF (0 dB).
- R2: A write whose data bit 8 is 0 updates only the pending latch of the addressed channel(s); no active output changes on the following cycle.
- R3: A write to any attenuation address with data bit 8 set loads every channel's active setting from its pending latch, visible one clock after the strobe. The value carried in that same word is included in the update.
- R4: On analogue address `ANA_BASE + k`, data bits 6:0 are the attenuation code of channel k and bit 7 is its zero-cross enable (1 = enabled). Both are staged together through pending and active.
- R5: A write to `MASTER_ADDR` loads data bits 6:0 and bit 7 into the pending latch of every analogue channel and leaves digital channels untouched.
- R6: On digital address `DIG_BASE + k`, data bits 7:0 are the attenuation code of digital channel k.
- R7: Bit 8 is not stored. A commit applies only to the write that carries it, and later writes with bit 8 clear do not change active outputs.
- R8: A write to an address outside the attenuation map changes no pending and no active state, even with bit 8 set.
- R9: While the write strobe is low, no state changes, whatever the address and data inputs hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Single-cycle write strobe |
| wr_addr | input | 5 | Register address |
| wr_data | input | 9 | Write data; bit 8 commits all channels |
| ana_att_o | output | N_ANA*7 | Active analogue codes, channel k at bits [7k+6:7k] |
| ana_zc_o | output | N_ANA | Active zero-cross enables, one per analogue channel |
| dig_att_o | output | N_DIG*8 | Active digital codes, channel k at bits [8k+7:8k] |

## Verification
A behavioural model in the bench tracks pending and active values and is compared with every output on every clock.

The directed part of the test covers several cases:
- Staged writes to one analogue and one digital channel, followed by a commit through a third channel. This separates "staged" from "applied" and shows whether the committing word's own value lands.
- A master broadcast committed by a single-channel write. This shows whether the later channel write overrides the broadcast only on its own channel.
- Writes with bit 8 set to unmapped addresses. These show whether such writes commit or corrupt any latch.

A long random stream of strobed and unstrobed writes over all 32 addresses then mixes every case.

// File: rtl/att_pkg.sv
package att_pkg;

    localparam int ADDR_W = 5;
    localparam int DATA_W = 9;
    localparam int ANA_W  = 7;
    localparam int DIG_W  = 8;
    localparam int COMMIT_BIT = 8;

    typedef enum logic [1:0] {
        K_NONE   = 2'd0,
        K_ANA    = 2'd1,
        K_MASTER = 2'd2,
        K_DIG    = 2'd3
    } addr_kind_e;

    typedef struct packed {
        logic             zc;
        logic [ANA_W-1:0] att;
    } ana_word_t;

    localparam ana_word_t ANA_RST = '{zc: 1'b0, att: {ANA_W{1'b1}}};
    localparam logic [DIG_W-1:0] DIG_RST = {DIG_W{1'b1}};

    function automatic addr_kind_e classify(input logic [ADDR_W-1:0] a,
                                            input int ana_base, input int n_ana,
                                            input int master,
                                            input int dig_base, input int n_dig);
        int ai;
        ai = int'(a);
        if (ai == master)                                  return K_MASTER;
        if (ai >= ana_base && ai < ana_base + n_ana)       return K_ANA;
        if (ai >= dig_base && ai < dig_base + n_dig)       return K_DIG;
        return K_NONE;
    endfunction

endpackage

// File: rtl/att_decode.sv
module att_decode
    import att_pkg::*;
#(
    parameter int N_ANA       = 8,
    parameter int N_DIG       = 8,
    parameter int ANA_BASE    = 0,
    parameter int MASTER_ADDR = 8,
    parameter int DIG_BASE    = 9
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic              commit_bit,
    output logic [N_ANA-1:0]  ana_hit,
    output logic [N_DIG-1:0]  dig_hit,
    output logic              commit
);

    addr_kind_e kind;

    always_comb begin
        kind = classify(wr_addr, ANA_BASE, N_ANA, MASTER_ADDR, DIG_BASE, N_DIG);
    end

    for (genvar k = 0; k < N_ANA; k++) begin : g_ana
        assign ana_hit[k] = wr_en &&
            (kind == K_MASTER ||
             (kind == K_ANA && wr_addr == ADDR_W'(ANA_BASE + k)));
    end

    for (genvar k = 0; k < N_DIG; k++) begin : g_dig
        assign dig_hit[k] = wr_en && kind == K_DIG &&
                            wr_addr == ADDR_W'(DIG_BASE + k);
    end

    assign commit = wr_en && commit_bit && (kind != K_NONE);

    // R9
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !wr_en |-> (!commit && ana_hit == '0 && dig_hit == '0));

    // R6
    dig_single_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(dig_hit) && !(|dig_hit && |ana_hit));

    // R8
    commit_mapped_chk: assert property (@(posedge clk) disable iff (rst)
        commit |-> (|ana_hit || |dig_hit));

    // R5
    master_all_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_addr == ADDR_W'(MASTER_ADDR)) |-> (&ana_hit));

endmodule

// File: rtl/att_stage.sv
module att_stage #(
    parameter int            W       = 8,
    parameter logic [W-1:0]  RST_VAL = '1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         ld,
    input  logic [W-1:0] din,
    input  logic         commit,
    output logic [W-1:0] act_o
);

    logic [W-1:0] pend_q;
    logic [W-1:0] pend_d;

    always_comb begin
        pend_d = ld ? din : pend_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q <= RST_VAL;
            act_o  <= RST_VAL;
        end else begin
            pend_q <= pend_d;
            if (commit) begin
                act_o <= pend_d;
            end
        end
    end

    // R1
    reset_value_chk: assert property (@(posedge clk)
        rst |=> (act_o == RST_VAL));

    // R2
    hold_active_chk: assert property (@(posedge clk) disable iff (rst)
        !commit |=> $stable(act_o));

    // R3
    same_word_chk: assert property (@(posedge clk) disable iff (rst)
        (commit && ld) |=> (act_o == $past(din)));

endmodule

// File: rtl/att_bank.sv
module att_bank
    import att_pkg::*;
#(
    parameter int N_ANA       = 8,
    parameter int N_DIG       = 8,
    parameter int ANA_BASE    = 0,
    parameter int MASTER_ADDR = 8,
    parameter int DIG_BASE    = 9
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   wr_en,
    input  logic [ADDR_W-1:0]      wr_addr,
    input  logic [DATA_W-1:0]      wr_data,
    output logic [N_ANA*ANA_W-1:0] ana_att_o,
    output logic [N_ANA-1:0]       ana_zc_o,
    output logic [N_DIG*DIG_W-1:0] dig_att_o
);

    localparam int ANA_WORD_W = $bits(ana_word_t);

    logic [N_ANA-1:0] ana_hit;
    logic [N_DIG-1:0] dig_hit;
    logic             commit;
    ana_word_t        ana_din;

    assign ana_din = ana_word_t'(wr_data[ANA_WORD_W-1:0]);

    att_decode #(
        .N_ANA(N_ANA), .N_DIG(N_DIG), .ANA_BASE(ANA_BASE),
        .MASTER_ADDR(MASTER_ADDR), .DIG_BASE(DIG_BASE)
    ) u_dec (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
        .commit_bit(wr_data[COMMIT_BIT]),
        .ana_hit(ana_hit), .dig_hit(dig_hit), .commit(commit)
    );

    for (genvar k = 0; k < N_ANA; k++) begin : g_ana
        ana_word_t act_w;
        att_stage #(.W(ANA_WORD_W), .RST_VAL(ANA_RST)) u_stage (
            .clk(clk), .rst(rst), .ld(ana_hit[k]), .din(ana_din),
            .commit(commit), .act_o(act_w)
        );
        assign ana_att_o[k*ANA_W +: ANA_W] = act_w.att;
        assign ana_zc_o[k]                 = act_w.zc;
    end

    for (genvar k = 0; k < N_DIG; k++) begin : g_dig
        att_stage #(.W(DIG_W), .RST_VAL(DIG_RST)) u_stage (
            .clk(clk), .rst(rst), .ld(dig_hit[k]),
            .din(wr_data[DIG_W-1:0]),
            .commit(commit), .act_o(dig_att_o[k*DIG_W +: DIG_W])
        );
    end

    // R7
    no_sticky_commit_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !wr_data[COMMIT_BIT]) |=>
            ($stable(ana_att_o) && $stable(ana_zc_o) && $stable(dig_att_o)));

    // R4
    ana_pair_chk: assert property (@(posedge clk) disable iff (rst)
        (commit && wr_addr == ADDR_W'(ANA_BASE)) |=>
            (ana_zc_o[0] == $past(wr_data[ANA_W]) &&
             ana_att_o[ANA_W-1:0] == $past(wr_data[ANA_W-1:0])));

endmodule

// File: tb/att_bank_tb.sv
module att_bank_tb;

    localparam int NA = 8;
    localparam int ND = 8;
    localparam int MASTER = 8;
    localparam int DBASE = 9;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              wr_en = 1'b0;
    logic [4:0]        wr_addr = '0;
    logic [8:0]        wr_data = '0;
    logic [NA*7-1:0]   ana_att_o;
    logic [NA-1:0]     ana_zc_o;
    logic [ND*8-1:0]   dig_att_o;

    int checks = 0;
    int errors = 0;
    bit cmp_en = 1'b0;
    string phase = "R1";

    int pa[NA];
    int aa[NA];
    int pd[ND];
    int ad[ND];

    always #4 clk = ~clk;

    att_bank u_dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .ana_att_o(ana_att_o), .ana_zc_o(ana_zc_o),
        .dig_att_o(dig_att_o)
    );

    // behavioural reference model
    always @(posedge clk) begin
        cmp_en <= 1'b1;
        if (rst) begin
            for (int k = 0; k < NA; k++) begin
                pa[k] = 'h7F;
                aa[k] = 'h7F;
            end
            for (int k = 0; k < ND; k++) begin
                pd[k] = 'hFF;
                ad[k] = 'hFF;
            end
        end else if (wr_en) begin
            int a;
            bit mapped;
            a = int'(wr_addr);
            mapped = 1'b0;
            if (a == MASTER) begin
                for (int k = 0; k < NA; k++) pa[k] = int'(wr_data[7:0]);
                mapped = 1'b1;
            end else if (a < NA) begin
                pa[a] = int'(wr_data[7:0]);
                mapped = 1'b1;
            end else if (a >= DBASE && a < DBASE + ND) begin
                pd[a-DBASE] = int'(wr_data[7:0]);
                mapped = 1'b1;
            end
            if (mapped && wr_data[8]) begin
                for (int k = 0; k < NA; k++) aa[k] = pa[k];
                for (int k = 0; k < ND; k++) ad[k] = pd[k];
            end
        end
    end

    // per-cycle comparison
    always @(negedge clk) begin
        if (cmp_en) begin
            bit bad;
            bad = 1'b0;
            for (int k = 0; k < NA; k++) begin
                if (int'(ana_att_o[k*7 +: 7]) != (aa[k] & 'h7F) ||
                    int'(ana_zc_o[k]) != ((aa[k] >> 7) & 1)) begin
                    $display("FAIL %s ana ch%0d: act att=%h zc=%b exp word=%h",
                             phase, k, ana_att_o[k*7 +: 7], ana_zc_o[k], aa[k]);
                    bad = 1'b1;
                end
            end
            for (int k = 0; k < ND; k++) begin
                if (int'(dig_att_o[k*8 +: 8]) != ad[k]) begin
                    $display("FAIL %s dig ch%0d: act=%h exp=%h",
                             phase, k, dig_att_o[k*8 +: 8], ad[k]);
                    bad = 1'b1;
                end
            end
            checks++;
            if (bad) errors++;
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input int a, input int d);
        wr_en   = 1'b1;
        wr_addr = 5'(a);
        wr_data = 9'(d);
        @(negedge clk);
        wr_en   = 1'b0;
    endtask

    initial begin
        #800000;
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset values
        chk("R1 ana7", int'(ana_att_o[49 +: 7]), 'h7F);
        chk("R1 zc", int'(ana_zc_o), 0);
        chk("R1 dig0", int'(dig_att_o[7:0]), 'hFF);
        rst = 1'b0;
        @(negedge clk);

        // R9 strobe low with busy inputs
        phase = "R9";
        wr_addr = 5'd0;
        wr_data = 9'h100;
        repeat (3) @(negedge clk);
        chk("R9 ana0", int'(ana_att_o[6:0]), 'h7F);

        // R2 / R4 / R6 staged writes
        phase = "R2";
        wr(6, 'h0A5);
        chk("R2 ana6 held", int'(ana_att_o[42 +: 7]), 'h7F);
        wr(DBASE + 1, 'h012);
        chk("R2 dig1 held", int'(dig_att_o[15:8]), 'hFF);

        // R3 commit via digital channel 0
        phase = "R3";
        wr(DBASE, 'h180);
        chk("R3 dig0 same word", int'(dig_att_o[7:0]), 'h80);
        chk("R4 ana6 att", int'(ana_att_o[42 +: 7]), 'h25);
        chk("R4 ana6 zc", int'(ana_zc_o[6]), 1);
        chk("R6 dig1", int'(dig_att_o[15:8]), 'h12);

        // R5 master broadcast, commit from ana2
        phase = "R5";
        wr(MASTER, 'h03C);
        chk("R5 not yet applied", int'(ana_att_o[0 +: 7]), 'h7F);
        wr(2, 'h155);
        chk("R5 ana0 master", int'(ana_att_o[0 +: 7]), 'h3C);
        chk("R5 ana6 zc cleared", int'(ana_zc_o[6]), 0);
        chk("R5 ana2 own", int'(ana_att_o[14 +: 7]), 'h55);
        chk("R5 dig1 untouched", int'(dig_att_o[15:8]), 'h12);

        // R7 bit 8 not retained
        phase = "R7";
        wr(3, 'h011);
        wr(DBASE + 2, 'h022);
        chk("R7 ana3 held", int'(ana_att_o[21 +: 7]), 'h3C);

        // R8 unmapped addresses
        phase = "R8";
        wr(20, 'h1FF);
        chk("R8 no commit", int'(ana_att_o[21 +: 7]), 'h3C);
        wr(31, 'h000);
        wr(DBASE + 7, 'h100);
        chk("R8 ana3 pending kept", int'(ana_att_o[21 +: 7]), 'h11);
        chk("R8 dig2", int'(dig_att_o[23:16]), 'h22);

        // random mix of all cases
        phase = "R3 random";
        for (int i = 0; i < 400; i++) begin
            wr_en   = ($urandom_range(0, 3) != 0);
            wr_addr = 5'($urandom_range(0, 31));
            wr_data = 9'($urandom_range(0, 511));
            @(negedge clk);
        end
        wr_en = 1'b0;
        @(negedge clk);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule